// File: doc/BRIEF.md
# Hash Engine APB Register Wrapper

This block is an APB slave that sits in front of a SHA-224/SHA-256 compression core. The core is outside the module and connects through plain ports. Software uses the wrapper to load a 512-bit message block as sixteen 32-bit words. It starts a first or follow-on compression by writing command bits, which the wrapper turns into one-cycle pulses. It also picks the digest width, polls the core's live ready and digest-valid levels, and reads the 256-bit digest back as eight words.

Two core events, a rising digest-valid and a rising ready, each set a sticky raw interrupt flag. A mask register enables each flag onto a single level-sensitive interrupt line. A masked-status view shows the flags that reach the line, and a write-one-to-clear register drops flags. A single-bit register drives an enable output for an external clock-gate cell.

Every APB access completes in its first access cycle and never signals an error. Addresses are byte addresses. The two low address bits must be zero for an access to hit a register.

Top module: `hash_apb_wrap`

## Requirements
- R1: After reset the mask, raw flags, mode and gate registers are zero, all sixteen block words are zero, and coreInit, coreNext, coreMode, clkGateEn and irq are low.
- R2: A write to byte offset 0x008 + 4*k, for k from 0 to 15, loads pwdata into coreBlock[32*k+31:32*k]. The other words keep their values.
- R3: A control write (offset 0x004) with bit 0 set raises coreInit for exactly one cycle. The pulse comes in the cycle after the access. Bit 1 does the same for coreNext. A command bit that is zero gives no pulse.
- R4: Control bit 2 is stored as a level on coreMode (0 selects SHA-224, 1 selects SHA-256). It changes only on a control write.
- R5: The status word at offset 0x000 is read-only. Bit 0 shows the core's live digest-valid and bit 1 its live ready. The upper bits read zero.
- R6: A read of offset 0x048 + 4*j, for j from 0 to 7, returns coreDigest[32*j+31:32*j].
- R7: The raw flag word (offset 0xFF08) has bit 0 VALID, set by a rising coreDigestValid, and bit 1 READY, set by a rising coreReady. A flag stays set after its source falls.
- R8: Writing 1 to a bit of the clear register (offset 0xFF0C) clears that raw flag, and writing 0 leaves it unchanged. When a set event and a clear of the same flag meet in one cycle, the flag ends up set.
- R9: The mask register (offset 0xFF00, bits 1:0) can be read back. The masked word (offset 0xFF04) reads raw AND mask, and writes to it change nothing.
- R10: irq is high exactly when some bit is set in both the raw flags and the mask.
- R11: Bit 0 of the gate register (offset 0xFF10) drives clkGateEn and reads back.
- R12: Reads of unmapped or unaligned addresses, and of the write-only control, block and clear registers, return zero. pready is always 1 and pslverr always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 16 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Transfer complete, tied high |
| pslverr | output | 1 | Error response, tied low |
| coreInit | output | 1 | One-cycle start-first-block pulse |
| coreNext | output | 1 | One-cycle continue-next-block pulse |
| coreMode | output | 1 | Digest width select, 1 = SHA-256 |
| coreBlock | output | 512 | Message block to the core |
| coreReady | input | 1 | Core can accept a command |
| coreDigest | input | 256 | Digest from the core |
| coreDigestValid | input | 1 | Digest is valid |
| clkGateEn | output | 1 | Enable for an external clock gate |
| irq | output | 1 | Interrupt request |

## Verification
The block loader gets about forty writes of random words to random slots. The full 512-bit port is compared after each one, which catches a wrong slice or a write that leaks into a neighbouring slot. The digest and status reads use random core values at every slot, so a swapped slice or bit order shows up. The interrupt path is walked through rise, sticky, clear-by-one, clear-by-zero and a clear that meets a set in the same cycle, followed by random mask and flag pairs that separate masked status and irq from raw. Random unaligned and unmapped addresses, plus reads of the write-only registers, check that nothing leaks onto the read bus.

// File: rtl/hash_apb_pkg.sv
package hash_apb_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 16;
  localparam int BLK_WORDS = 16;
  localparam int DIG_WORDS = 8;
  localparam int NUM_IRQ   = 2;
  localparam int BLK_IDX_W = $clog2(BLK_WORDS);
  localparam int DIG_IDX_W = $clog2(DIG_WORDS);

  // word (address >> 2) locations
  localparam int W_STATUS = 'h000 >> 2;
  localparam int W_CTRL   = 'h004 >> 2;
  localparam int W_BLK0   = 'h008 >> 2;
  localparam int W_DIG0   = W_BLK0 + BLK_WORDS;
  localparam int W_MASK   = 'hFF00 >> 2;
  localparam int W_MASKED = 'hFF04 >> 2;
  localparam int W_RAW    = 'hFF08 >> 2;
  localparam int W_CLEAR  = 'hFF0C >> 2;
  localparam int W_GATE   = 'hFF10 >> 2;

  // control and flag bit positions
  localparam int CTL_INIT = 0;
  localparam int CTL_NEXT = 1;
  localparam int CTL_MODE = 2;
  localparam int FLG_VALID = 0;
  localparam int FLG_READY = 1;

  typedef enum logic [2:0] {
    RD_NONE, RD_STATUS, RD_DIGEST, RD_MASK, RD_MASKED, RD_RAW, RD_GATE
  } rdSel_e;

  typedef struct packed {
    logic                 wrCtrl;
    logic                 wrBlk;
    logic [BLK_IDX_W-1:0] blkIdx;
    logic                 wrMask;
    logic                 wrClr;
    logic                 wrGate;
    rdSel_e               rdSel;
    logic [DIG_IDX_W-1:0] digIdx;
  } strobe_t;
endpackage

// File: rtl/hash_apb_decode.sv
module hash_apb_decode
  import hash_apb_pkg::*;
(
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output strobe_t           strb
);
  logic wrAcc;
  logic aligned;
  int   wordIdx;
  int   blkOff;
  int   digOff;

  assign wrAcc   = psel & penable & pwrite;
  assign aligned = (paddr[1:0] == 2'b00);

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    wordIdx    = int'(paddr[ADDR_W-1:2]);
    blkOff     = wordIdx - W_BLK0;
    digOff     = wordIdx - W_DIG0;
    if (aligned) begin
      if (wordIdx == W_STATUS) begin
        strb.rdSel = RD_STATUS;
      end else if (wordIdx == W_CTRL) begin
        strb.wrCtrl = wrAcc;
      end else if (wordIdx >= W_BLK0 && wordIdx < W_BLK0 + BLK_WORDS) begin
        strb.wrBlk  = wrAcc;
        strb.blkIdx = blkOff[BLK_IDX_W-1:0];
      end else if (wordIdx >= W_DIG0 && wordIdx < W_DIG0 + DIG_WORDS) begin
        strb.rdSel  = RD_DIGEST;
        strb.digIdx = digOff[DIG_IDX_W-1:0];
      end else if (wordIdx == W_MASK) begin
        strb.wrMask = wrAcc;
        strb.rdSel  = RD_MASK;
      end else if (wordIdx == W_MASKED) begin
        strb.rdSel  = RD_MASKED;
      end else if (wordIdx == W_RAW) begin
        strb.rdSel  = RD_RAW;
      end else if (wordIdx == W_CLEAR) begin
        strb.wrClr  = wrAcc;
      end else if (wordIdx == W_GATE) begin
        strb.wrGate = wrAcc;
        strb.rdSel  = RD_GATE;
      end
    end
  end
endmodule

// File: rtl/hash_apb_regs.sv
module hash_apb_regs
  import hash_apb_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strb,
  input  logic                          rdEn,
  input  logic [DATA_W-1:0]             pwdata,
  output logic [DATA_W-1:0]             prdata,
  output logic                          coreInit,
  output logic                          coreNext,
  output logic                          coreMode,
  output logic [BLK_WORDS*DATA_W-1:0]   coreBlock,
  input  logic                          coreReady,
  input  logic [DIG_WORDS*DATA_W-1:0]   coreDigest,
  input  logic                          coreDigestValid,
  output logic                          clkGateEn,
  output logic                          irq
);
  logic [DATA_W-1:0]  blockWords [BLK_WORDS];
  logic [NUM_IRQ-1:0] maskReg, rawReg, prevEvt, evtNow, setEvt, clrBits, maskedBits;
  logic               gateReg;

  for (genvar w = 0; w < BLK_WORDS; w++) begin : g_blk
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        blockWords[w] <= '0;
      else if (strb.wrBlk && strb.blkIdx == BLK_IDX_W'(w))
        blockWords[w] <= pwdata;
    end
    assign coreBlock[w*DATA_W +: DATA_W] = blockWords[w];
  end

  // command pulses and mode level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreInit <= 1'b0;
      coreNext <= 1'b0;
      coreMode <= 1'b0;
    end else begin
      coreInit <= strb.wrCtrl & pwdata[CTL_INIT];
      coreNext <= strb.wrCtrl & pwdata[CTL_NEXT];
      if (strb.wrCtrl) coreMode <= pwdata[CTL_MODE];
    end
  end

  // interrupt flags
  always_comb begin
    evtNow             = '0;
    evtNow[FLG_VALID]  = coreDigestValid;
    evtNow[FLG_READY]  = coreReady;
  end
  assign setEvt     = evtNow & ~prevEvt;
  assign clrBits    = strb.wrClr ? pwdata[NUM_IRQ-1:0] : '0;
  assign maskedBits = rawReg & maskReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevEvt <= '0;
      rawReg  <= '0;
      maskReg <= '0;
      gateReg <= 1'b0;
    end else begin
      prevEvt <= evtNow;
      rawReg  <= (rawReg & ~clrBits) | setEvt;
      if (strb.wrMask) maskReg <= pwdata[NUM_IRQ-1:0];
      if (strb.wrGate) gateReg <= pwdata[0];
    end
  end

  assign irq       = |maskedBits;
  assign clkGateEn = gateReg;

  // read multiplexer
  always_comb begin
    prdata = '0;
    if (rdEn) begin
      unique case (strb.rdSel)
        RD_STATUS: begin
          prdata[FLG_VALID] = coreDigestValid;
          prdata[FLG_READY] = coreReady;
        end
        RD_DIGEST: prdata = coreDigest[strb.digIdx*DATA_W +: DATA_W];
        RD_MASK:   prdata[NUM_IRQ-1:0] = maskReg;
        RD_MASKED: prdata[NUM_IRQ-1:0] = maskedBits;
        RD_RAW:    prdata[NUM_IRQ-1:0] = rawReg;
        RD_GATE:   prdata[0] = gateReg;
        default:   prdata = '0;
      endcase
    end
  end

  // R3: command pulses last one cycle
  p_init_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    coreInit |=> !coreInit);
  p_next_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    coreNext |=> !coreNext);
  // R4: mode moves only on a control write
  p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrCtrl |=> $stable(coreMode));
  // R7: rising core events land in the raw flags
  p_valid_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreDigestValid) |=> rawReg[FLG_VALID]);
  p_ready_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreReady) |=> rawReg[FLG_READY]);
  // R8: a clear with no competing set drops the flag
  p_valid_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrClr && pwdata[FLG_VALID] && !setEvt[FLG_VALID]) |=> !rawReg[FLG_VALID]);
  // R10: no interrupt while the mask is empty
  p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rstN)
    (maskReg == '0) |-> !irq);
endmodule

// File: rtl/hash_apb_wrap.sv
module hash_apb_wrap
  import hash_apb_pkg::*;
(
  input  logic          pclk,
  input  logic          presetn,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [15:0]   paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  output logic          pready,
  output logic          pslverr,
  output logic          coreInit,
  output logic          coreNext,
  output logic          coreMode,
  output logic [511:0]  coreBlock,
  input  logic          coreReady,
  input  logic [255:0]  coreDigest,
  input  logic          coreDigestValid,
  output logic          clkGateEn,
  output logic          irq
);
  strobe_t strb;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  hash_apb_decode i_decode (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .strb    (strb)
  );

  hash_apb_regs i_regs (
    .clk             (pclk),
    .rstN            (presetn),
    .strb            (strb),
    .rdEn            (psel & ~pwrite),
    .pwdata          (pwdata),
    .prdata          (prdata),
    .coreInit        (coreInit),
    .coreNext        (coreNext),
    .coreMode        (coreMode),
    .coreBlock       (coreBlock),
    .coreReady       (coreReady),
    .coreDigest      (coreDigest),
    .coreDigestValid (coreDigestValid),
    .clkGateEn       (clkGateEn),
    .irq             (irq)
  );
endmodule

// File: tb/test_hash_apb_wrap.sv
`timescale 1ns/1ps
module test_hash_apb_wrap;
  logic         pclk = 1'b0;
  logic         presetn = 1'b0;
  logic         psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [15:0]  paddr = '0;
  logic [31:0]  pwdata = '0;
  logic [31:0]  prdata;
  logic         pready, pslverr;
  logic         coreInit, coreNext, coreMode;
  logic [511:0] coreBlock;
  logic         coreReady = 1'b0;
  logic [255:0] coreDigest = '0;
  logic         coreDigestValid = 1'b0;
  logic         clkGateEn, irq;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 0;

  always #10 pclk = ~pclk;

  hash_apb_wrap i_hash_apb_wrap (.*);

  task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apbWrite(input logic [15:0] a, input logic [31:0] d, input bit riseValid = 0);
    @(negedge pclk);
    psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1;
    if (riseValid) coreDigestValid = 1;
    @(negedge pclk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apbRead(input logic [15:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge pclk);
    penable = 1;
    #1;
    d = prdata;
    chk(pready === 1'b1 && pslverr === 1'b0, "R12 handshake", {pready, pslverr}, 2'b10);
    @(negedge pclk);
    psel = 0; penable = 0;
  endtask

  function automatic logic [1:0] expMasked(input logic [1:0] raw, input logic [1:0] mask);
    return raw & mask;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge pclk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin : main
    logic [31:0]  rd;
    logic [31:0]  model [16];
    logic [511:0] expBlk;
    logic [1:0]   rawExp, maskV;
    void'($urandom(32'hC0FFEE));
    for (int k = 0; k < 16; k++) model[k] = '0;
    repeat (3) @(negedge pclk);
    presetn = 1;
    @(negedge pclk);

    // R1 reset state
    chk(coreBlock === '0, "R1 block zero", coreBlock, 0);
    chk({coreInit, coreNext, coreMode, clkGateEn, irq} === 5'b0, "R1 outputs low",
        {coreInit, coreNext, coreMode, clkGateEn, irq}, 0);
    apbRead(16'hFF00, rd); chk(rd === 0, "R1 mask zero", rd, 0);
    apbRead(16'hFF08, rd); chk(rd === 0, "R1 raw zero", rd, 0);
    apbRead(16'hFF10, rd); chk(rd === 0, "R1 gate zero", rd, 0);

    // R2 random block loading
    for (int n = 0; n < 40; n++) begin
      int k = $urandom_range(0, 15);
      logic [31:0] v = $urandom;
      apbWrite(16'(8 + 4*k), v);
      model[k] = v;
      for (int j = 0; j < 16; j++) expBlk[32*j +: 32] = model[j];
      chk(coreBlock === expBlk, "R2 block word", coreBlock, expBlk);
    end
    // R12 block and control read back as zero
    apbRead(16'h0008, rd); chk(rd === 0, "R12 block reads zero", rd, 0);
    apbRead(16'h0004, rd); chk(rd === 0, "R12 ctrl reads zero", rd, 0);

    // R3 and R4 command pulses and mode
    apbWrite(16'h0004, 32'h4);
    chk({coreInit, coreNext, coreMode} === 3'b001, "R4 mode set no pulse", {coreInit, coreNext, coreMode}, 3'b001);
    apbWrite(16'h0004, 32'h1);
    chk({coreInit, coreNext} === 2'b10, "R3 init pulse", {coreInit, coreNext}, 2'b10);
    chk(coreMode === 1'b0, "R4 mode cleared", coreMode, 0);
    @(negedge pclk);
    chk(coreInit === 1'b0, "R3 init one cycle", coreInit, 0);
    apbWrite(16'h0004, 32'h6);
    chk({coreInit, coreNext, coreMode} === 3'b011, "R3 next pulse", {coreInit, coreNext, coreMode}, 3'b011);
    @(negedge pclk);
    chk(coreNext === 1'b0 && coreMode === 1'b1, "R4 next one cycle mode held", {coreNext, coreMode}, 2'b01);

    // R5 status and R6 digest
    for (int n = 0; n < 4; n++) begin
      coreDigestValid = n[0]; coreReady = n[1];
      apbRead(16'h0000, rd);
      chk(rd === {30'b0, n[1], n[0]}, "R5 status bits", rd, {30'b0, n[1], n[0]});
    end
    for (int j = 0; j < 8; j++) coreDigest[32*j +: 32] = $urandom;
    for (int j = 0; j < 8; j++) begin
      apbRead(16'(16'h48 + 4*j), rd);
      chk(rd === coreDigest[32*j +: 32], "R6 digest word", rd, coreDigest[32*j +: 32]);
    end

    // R7 raw flags: both were raised above, clear them first
    coreDigestValid = 0; coreReady = 0;
    apbWrite(16'hFF0C, 32'h3);
    apbRead(16'hFF08, rd); chk(rd === 0, "R8 clear both", rd, 0);
    @(negedge pclk); coreDigestValid = 1;
    apbRead(16'hFF08, rd); chk(rd === 32'h1, "R7 valid rise", rd, 1);
    coreReady = 1;
    apbRead(16'hFF08, rd); chk(rd === 32'h3, "R7 ready rise", rd, 3);
    coreDigestValid = 0; coreReady = 0;
    apbRead(16'hFF08, rd); chk(rd === 32'h3, "R7 sticky", rd, 3);
    apbWrite(16'hFF0C, 32'h0);
    apbRead(16'hFF08, rd); chk(rd === 32'h3, "R8 zero no effect", rd, 3);
    apbWrite(16'hFF0C, 32'h1);
    apbRead(16'hFF08, rd); chk(rd === 32'h2, "R8 clear valid", rd, 2);
    apbWrite(16'hFF0C, 32'h1, 1);
    apbRead(16'hFF08, rd); chk(rd === 32'h3, "R8 set wins", rd, 3);
    coreDigestValid = 0;

    // R9 and R10 mask, masked, irq
    rawExp = 2'b11;
    for (int n = 0; n < 12; n++) begin
      logic [1:0] clr = 2'($urandom);
      maskV = 2'($urandom);
      apbWrite(16'hFF0C, {30'b0, clr});
      rawExp = rawExp & ~clr;
      apbWrite(16'hFF00, {30'b0, maskV});
      apbRead(16'hFF00, rd); chk(rd === {30'b0, maskV}, "R9 mask readback", rd, maskV);
      apbWrite(16'hFF04, 32'hFFFF_FFFF);
      apbRead(16'hFF04, rd);
      chk(rd === {30'b0, expMasked(rawExp, maskV)}, "R9 masked", rd, expMasked(rawExp, maskV));
      apbRead(16'hFF08, rd); chk(rd === {30'b0, rawExp}, "R9 raw unchanged by masked write", rd, rawExp);
      chk(irq === |expMasked(rawExp, maskV), "R10 irq", irq, |expMasked(rawExp, maskV));
      if (rawExp == 0) begin
        @(negedge pclk); coreDigestValid = 1; coreReady = 1;
        @(negedge pclk); coreDigestValid = 0; coreReady = 0;
        rawExp = 2'b11;
      end
    end

    // R11 gate
    apbWrite(16'hFF10, 32'h1);
    chk(clkGateEn === 1'b1, "R11 gate on", clkGateEn, 1);
    apbRead(16'hFF10, rd); chk(rd === 32'h1, "R11 gate readback", rd, 1);
    apbWrite(16'hFF10, 32'h0);
    chk(clkGateEn === 1'b0, "R11 gate off", clkGateEn, 0);

    // R12 unmapped and unaligned
    apbRead(16'hFF0C, rd); chk(rd === 0, "R12 clear reads zero", rd, 0);
    for (int n = 0; n < 10; n++) begin
      logic [15:0] a = 16'($urandom_range(16'h0100, 16'hFE00));
      apbRead(a, rd); chk(rd === 0, "R12 unmapped", rd, 0);
    end
    apbRead(16'h0049, rd); chk(rd === 0, "R12 unaligned", rd, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule